// File: doc/BRIEF.md
# Way-Splittable Write-Back Data Cache

This block is a four-way set-associative data cache with write-allocate and write-back. It serves one CPU word request at a time and fetches or writes whole 16-byte lines over a simple external memory port. A level input `ram_mode` splits the ways. When it is low, all four ways cache. When it is high, ways 0 and 1 form a two-way cache. Ways 2 and 3 then become a directly addressed on-chip RAM of 4 KB. That RAM answers every word address whose top byte is 0x7F, and it repeats every 4 KB across that 16 MB window.

When a miss evicts a modified line, the line goes into a one-entry write-back buffer. The buffer writes the line out only after the refill data has arrived. Any request to the line held in the buffer waits until that write has been accepted.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the response for that request has been given. The response is a single-cycle `rsp_valid` pulse and cannot be held back. The read-address port and the line-write port are valid/ready. The block holds valid and payload steady until ready is seen. Refill data on `mem_rdata_valid` is always taken. `inv_all` is a one-cycle strobe that is honoured while the block is idle. The mode may only change after an invalidate-all. A mode change without one leaves the contents undefined.

Top module: `split_cache`

## Requirements
- R1: After reset, `req_ready` is high, and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are low.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high, and only one is outstanding. For a cache hit or a RAM-window access, `rsp_valid` is high for exactly one cycle, in the cycle after the second rising edge counted from the accepting edge.
- R3: A read returns the most recent value written to that word address, across misses, evictions and write-backs.
- R4: In normal mode, four different lines that map to the same set can all be resident at once. Re-reading them causes no external read.
- R5: The victim is the lowest-numbered invalid way that is allowed. Otherwise a 3-bit tree pseudo-LRU picks it, with the root choosing the pair and one bit per pair. In RAM mode only ways 0 and 1 are candidates, and the choice between them is exact LRU.
- R6: With `ram_mode` high, a word address with top byte 0x7F accesses internal RAM, with no external traffic. Byte-address bit 11 selects way 2 or way 3, bits 10:4 select the set and bits 3:2 select the word.
- R7: Within the RAM window, byte-address bits 23:12 are ignored, so every 4 KB alias reaches the same word.
- R8: `bypass` is high exactly when `ram_mode` is high and the top byte of `req_waddr` (as a byte address) is 0x7F. It follows the port combinationally.
- R9: A dirty victim is copied into the write-back buffer. Its write, to the line base address with all 128 bits (word 0 in bits 31:0), starts only after the refill data for the miss has arrived.
- R10: A request whose line is held in the write-back buffer issues no external read until that buffer's write handshake has completed.
- R11: An `inv_all` strobe while idle clears all valid and dirty state without writing anything back. The next access to a previously cached line misses.
- R12: `mem_rd_valid` with `mem_rd_addr`, and `mem_wr_valid` with `mem_wr_addr` and `mem_wr_line`, stay stable until their ready is seen.
- R13: A write hit marks the line dirty. A clean victim is dropped without any external write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_mode | input | 1 | High: ways 2/3 act as internal RAM |
| inv_all | input | 1 | One-cycle strobe clearing all valid and dirty bits |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | High for a word write |
| req_waddr | input | 30 | Word address (byte address bits 31:2) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data (write data echoed for writes) |
| bypass | output | 1 | Address falls in the untranslated RAM window |
| mem_rd_valid | output | 1 | Line read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Line base byte address of the read |
| mem_rdata_valid | input | 1 | Refill line present |
| mem_rdata | input | 128 | Refill line, word 0 in bits 31:0 |
| mem_wr_valid | output | 1 | Line write valid |
| mem_wr_ready | input | 1 | Memory accepts the line write |
| mem_wr_addr | output | 32 | Line base byte address of the write |
| mem_wr_line | output | 128 | Line data, word 0 in bits 31:0 |

## Verification
A hit or a RAM access produces `rsp_valid` in the cycle after the second rising edge counted from the accepting edge. The bench counts falling edges from acceptance and expects exactly two for those cases. A miss adds the memory's handshake and latency, so the bench waits for the pulse and checks only the data and the external traffic counts.

Write-back ordering is checked against cycle stamps that the memory model records at falling edges. The line write must first appear after the refill data cycle. The stalled read's address handshake must come after the write handshake. The `bypass` flag is combinational, so it is sampled on the falling edge after the address is driven.

// File: rtl/splitc_pkg.sv
package splitc_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int WAYS       = 4;   // tree replacement below assumes four ways
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int OFF_W      = $clog2(LINE_WORDS * WORD_W / 8);
  localparam int WOFF_W     = $clog2(LINE_WORDS);
  localparam int WA_W       = ADDR_W - 2;
  localparam logic [7:0] RAM_TOP = 8'h7F;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FREQ, ST_FWAIT} cst_e;
endpackage

// File: rtl/sc_tags.sv
module sc_tags
  import splitc_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inv_i,
  input  logic                     ram_mode_i,
  input  logic [$clog2(SETS)-1:0]  set_i,
  input  logic [TAG_W-1:0]         tag_i,
  output logic                     hit_o,
  output logic [1:0]               hit_way_o,
  output logic [1:0]               vic_way_o,
  output logic                     vic_dirty_o,
  output logic [TAG_W-1:0]         vic_tag_o,
  input  logic                     touch_i,
  input  logic                     mark_dirty_i,
  input  logic                     fill_i,
  input  logic [1:0]               fill_way_i
);
  logic [TAG_W-1:0] tag_q   [WAYS][SETS];
  logic [SETS-1:0]  valid_q [WAYS];
  logic [SETS-1:0]  dirty_q [WAYS];
  logic [2:0]       lru_q   [SETS];
  logic [WAYS-1:0]  allow, way_hit, way_free;
  logic [2:0]       tree;

  assign allow = ram_mode_i ? 4'b0011 : 4'b1111;
  assign tree  = lru_q[set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w]  = allow[w] && valid_q[w][set_i] && (tag_q[w][set_i] == tag_i);
    assign way_free[w] = allow[w] && !valid_q[w][set_i];
  end

  always_comb begin
    hit_way_o = '0;
    vic_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w])  hit_way_o = 2'(w);
      if (way_free[w]) vic_way_o = 2'(w);
    end
    if (way_free == '0) begin
      if (ram_mode_i || !tree[0]) vic_way_o = {1'b0, tree[1]};
      else                        vic_way_o = {1'b1, tree[2]};
    end
  end

  assign hit_o       = |way_hit;
  assign vic_dirty_o = valid_q[vic_way_o][set_i] && dirty_q[vic_way_o][set_i];
  assign vic_tag_o   = tag_q[vic_way_o][set_i];

  always_ff @(posedge clk) begin
    if (fill_i) tag_q[fill_way_i][set_i] <= tag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (inv_i) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
    end else begin
      if (fill_i) begin
        valid_q[fill_way_i][set_i] <= 1'b1;
        dirty_q[fill_way_i][set_i] <= 1'b0;
      end
      if (touch_i) begin
        lru_q[set_i][0] <= ~hit_way_o[1];
        if (hit_way_o[1]) lru_q[set_i][2] <= ~hit_way_o[0];
        else              lru_q[set_i][1] <= ~hit_way_o[0];
        if (mark_dirty_i) dirty_q[hit_way_o][set_i] <= 1'b1;
      end
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R3
  AST_RAM_VICTIM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_mode_i && !hit_o) |-> !vic_way_o[1]); // R5
endmodule

// File: rtl/sc_data.sv
module sc_data
  import splitc_pkg::*;
#(
  parameter int SETS = 128
) (
  input  logic                     clk,
  input  logic [$clog2(SETS)-1:0]  set_i,
  input  logic [1:0]               way_a_i,
  output logic [LINE_W-1:0]        line_a_o,
  input  logic [1:0]               way_b_i,
  output logic [LINE_W-1:0]        line_b_o,
  input  logic                     wr_i,
  input  logic [WOFF_W-1:0]        word_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic                     fill_i,
  input  logic [1:0]               fill_way_i,
  input  logic [LINE_W-1:0]        fill_line_i
);
  logic [LINE_W-1:0] line_q [WAYS][SETS];

  assign line_a_o = line_q[way_a_i][set_i];
  assign line_b_o = line_q[way_b_i][set_i];

  always_ff @(posedge clk) begin
    if (fill_i)    line_q[fill_way_i][set_i] <= fill_line_i;
    else if (wr_i) line_q[way_a_i][set_i][word_i*WORD_W +: WORD_W] <= wdata_i;
  end
endmodule

// File: rtl/sc_wbuf.sv
module sc_wbuf
  import splitc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [ADDR_W-OFF_W-1:0]   load_la_i,
  input  logic [LINE_W-1:0]         load_line_i,
  input  logic                      arm_i,
  input  logic [ADDR_W-OFF_W-1:0]   probe_la_i,
  output logic                      match_o,
  output logic                      busy_o,
  output logic                      wr_valid_o,
  input  logic                      wr_ready_i,
  output logic [ADDR_W-OFF_W-1:0]   wr_la_o,
  output logic [LINE_W-1:0]         wr_line_o
);
  logic held_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      held_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (wr_valid_o && wr_ready_i) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_i && held_q) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      wr_la_o   <= load_la_i;
      wr_line_o <= load_line_i;
    end
  end

  assign busy_o     = held_q;
  assign wr_valid_o = held_q && armed_q;
  assign match_o    = held_q && (wr_la_o == probe_la_i);

  AST_WB_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !held_q); // R9
  AST_WB_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_la_o) && $stable(wr_line_o))); // R12
endmodule

// File: rtl/split_cache.sv
module split_cache
  import splitc_pkg::*;
#(
  parameter int SETS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ram_mode,
  input  logic                inv_all,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [WA_W-1:0]     req_waddr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                bypass,
  output logic                mem_rd_valid,
  input  logic                mem_rd_ready,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic                mem_rdata_valid,
  input  logic [LINE_W-1:0]   mem_rdata,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [ADDR_W-1:0]   mem_wr_addr,
  output logic [LINE_W-1:0]   mem_wr_line
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = WA_W - SET_W - WOFF_W;
  localparam int LA_W  = ADDR_W - OFF_W;

  cst_e              st_q;
  logic              we_q;
  logic [WA_W-1:0]   addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [1:0]        vic_q;

  logic [SET_W-1:0]  set_w;
  logic [TAG_W-1:0]  tag_w, vic_tag;
  logic [WOFF_W-1:0] word_w;
  logic [LA_W-1:0]   la_w, wb_la;
  logic              hit, vic_dirty, in_ram, look, serve, go_fill, fill, wb_match, wb_busy;
  logic [1:0]        hit_way, vic_way, way_a;
  logic [LINE_W-1:0] line_a, line_b;

  assign set_w  = addr_q[WOFF_W +: SET_W];
  assign tag_w  = addr_q[WA_W-1 -: TAG_W];
  assign word_w = addr_q[WOFF_W-1:0];
  assign la_w   = addr_q[WA_W-1:WOFF_W];
  assign in_ram = ram_mode && (addr_q[WA_W-1 -: 8] == RAM_TOP);
  assign bypass = ram_mode && (req_waddr[WA_W-1 -: 8] == RAM_TOP);

  assign look    = (st_q == ST_LOOK);
  assign serve   = look && (in_ram || hit);
  assign go_fill = look && !in_ram && !hit && !wb_match && !(vic_dirty && wb_busy);
  assign fill    = (st_q == ST_FWAIT) && mem_rdata_valid;
  assign way_a   = in_ram ? {1'b1, addr_q[WOFF_W + SET_W]} : hit_way;

  assign req_ready    = (st_q == ST_IDLE) && !inv_all;
  assign mem_rd_valid = (st_q == ST_FREQ);
  assign mem_rd_addr  = {la_w, {OFF_W{1'b0}}};
  assign mem_wr_addr  = {wb_la, {OFF_W{1'b0}}};

  sc_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .inv_i(inv_all && st_q == ST_IDLE), .ram_mode_i(ram_mode),
    .set_i(set_w), .tag_i(tag_w),
    .hit_o(hit), .hit_way_o(hit_way),
    .vic_way_o(vic_way), .vic_dirty_o(vic_dirty), .vic_tag_o(vic_tag),
    .touch_i(serve && !in_ram), .mark_dirty_i(we_q),
    .fill_i(fill), .fill_way_i(vic_q)
  );

  sc_data #(.SETS(SETS)) u_data (
    .clk, .set_i(set_w),
    .way_a_i(way_a), .line_a_o(line_a),
    .way_b_i(vic_way), .line_b_o(line_b),
    .wr_i(serve && we_q), .word_i(word_w), .wdata_i(wdata_q),
    .fill_i(fill), .fill_way_i(vic_q), .fill_line_i(mem_rdata)
  );

  sc_wbuf u_wbuf (
    .clk, .rst_n,
    .load_i(go_fill && vic_dirty), .load_la_i({vic_tag, set_w}), .load_line_i(line_b),
    .arm_i(fill), .probe_la_i(la_w), .match_o(wb_match), .busy_o(wb_busy),
    .wr_valid_o(mem_wr_valid), .wr_ready_i(mem_wr_ready),
    .wr_la_o(wb_la), .wr_line_o(mem_wr_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      vic_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid && req_ready) begin
          we_q    <= req_we;
          addr_q  <= req_waddr;
          wdata_q <= req_wdata;
          st_q    <= ST_LOOK;
        end
        ST_LOOK: if (serve) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= we_q ? wdata_q : line_a[word_w*WORD_W +: WORD_W];
          st_q      <= ST_IDLE;
        end else if (go_fill) begin
          vic_q <= vic_way;
          st_q  <= ST_FREQ;
        end
        ST_FREQ:  if (mem_rd_ready)    st_q <= ST_FWAIT;
        ST_FWAIT: if (mem_rdata_valid) st_q <= ST_LOOK;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_FROM_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(st_q == ST_LOOK)); // R2
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R12
  AST_DRAIN_AFTER_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_valid) |-> $past(mem_rdata_valid)); // R9
  AST_NO_FETCH_OF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !(wb_busy && wb_la == mem_rd_addr[ADDR_W-1:OFF_W])); // R10
endmodule

// File: tb/tb_split_cache.sv
`timescale 1ns/1ps
module tb_split_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ram_mode = 1'b0, inv_all = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [29:0] req_waddr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, bypass, mem_rd_valid, mem_wr_valid;
  logic [31:0] rsp_rdata, mem_rd_addr, mem_wr_addr;
  logic mem_rd_ready, mem_rdata_valid, mem_wr_ready;
  logic [127:0] mem_rdata, mem_wr_line;

  always #2.5 clk = ~clk;

  split_cache dut (
    .clk, .rst_n, .ram_mode, .inv_all, .req_valid, .req_ready, .req_we, .req_waddr,
    .req_wdata, .rsp_valid, .rsp_rdata, .bypass, .mem_rd_valid, .mem_rd_ready,
    .mem_rd_addr, .mem_rdata_valid, .mem_rdata, .mem_wr_valid, .mem_wr_ready,
    .mem_wr_addr, .mem_wr_line
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int rd_count = 0, wr_count = 0, wr_extra = 0;
  int rd_hs_cyc = 0, rd_data_cyc = 0, wr_seen_cyc = 0, wr_hs_cyc = 0;
  logic [31:0]  last_wr_addr = '0;
  logic [127:0] last_wr_line = '0;
  logic [27:0]  rd_la, wr_la;
  logic [127:0] ext [logic [27:0]];
  logic [31:0]  refw [logic [29:0]];
  logic [31:0]  ramw [1024];
  logic         ramk [1024];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] ext_line(input logic [27:0] la);
    logic [127:0] l;
    if (ext.exists(la)) return ext[la];
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = {la, 2'(k), 2'b00} ^ 32'h5A00_0000;
    return l;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [127:0] l;
    if (refw.exists(a[31:2])) return refw[a[31:2]];
    l = ext_line(a[31:4]);
    return l[a[3:2]*32 +: 32];
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory read side
  initial begin
    mem_rd_ready = 1'b0; mem_rdata_valid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_rd_ready = 1'b1; rd_la = mem_rd_addr[31:4];
        @(negedge clk);
        mem_rd_ready = 1'b0; rd_count++; rd_hs_cyc = cyc;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        mem_rdata = ext_line(rd_la); mem_rdata_valid = 1'b1; rd_data_cyc = cyc;
        @(negedge clk);
        mem_rdata_valid = 1'b0;
      end
    end
  end

  // memory write side
  initial begin
    mem_wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_wr_valid) begin
        wr_seen_cyc = cyc;
        repeat (wr_extra + $urandom_range(0, 2)) @(negedge clk);
        mem_wr_ready = 1'b1; wr_la = mem_wr_addr[31:4];
        last_wr_addr = mem_wr_addr; last_wr_line = mem_wr_line;
        @(negedge clk);
        mem_wr_ready = 1'b0; ext[wr_la] = last_wr_line; wr_count++; wr_hs_cyc = cyc;
      end
    end
  end

  task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d,
                    output logic [31:0] q, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_waddr = a[31:2]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    q = rsp_rdata;
    if (lat >= 2000) check(1'b0, "R2 response timeout", lat, 0);
  endtask

  function automatic bit in_win(input logic [31:0] a);
    return ram_mode && a[31:24] == 8'h7F;
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] q; int lat;
    op(1'b1, a, d, q, lat);
    if (in_win(a)) begin ramw[a[11:2]] = d; ramk[a[11:2]] = 1'b1; end
    else refw[a[31:2]] = d;
  endtask

  task automatic rd(input logic [31:0] a, input string req, output int lat);
    logic [31:0] q, e;
    op(1'b0, a, 32'h0, q, lat);
    if (in_win(a)) begin
      if (ramk[a[11:2]]) check(q == ramw[a[11:2]], req, q, ramw[a[11:2]]);
    end else begin
      e = exp_word(a);
      check(q == e, req, q, e);
    end
  endtask

  function automatic logic [31:0] la_of(input int tag, input int set);
    return (32'(tag) << 11) | (32'(set) << 4);
  endfunction

  task automatic pulse_inv();
    repeat (40) @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    refw.delete();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, r0, w0, rdc;
    logic [31:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) ramk[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    check(rsp_valid === 1'b0 && mem_rd_valid === 1'b0 && mem_wr_valid === 1'b0,
          "R1 idle outputs", {rsp_valid, mem_rd_valid, mem_wr_valid}, 0);

    // R8 in normal mode: window address does not bypass
    req_waddr = 30'h1FC0_0004;
    @(negedge clk);
    check(bypass === 1'b0, "R8 bypass low in normal mode", bypass, 0);

    // R4 / R5 normal mode, set 5
    r0 = rd_count;
    for (int t = 1; t <= 4; t++) rd(la_of(t, 5), "R3 fill read", lat);
    check(rd_count - r0 == 4, "R4 four fills", rd_count - r0, 4);
    r0 = rd_count;
    for (int t = 1; t <= 4; t++) begin
      rd(la_of(t, 5), "R3 re-read", lat);
      check(lat == 2, "R2 hit latency", lat, 2);
    end
    check(rd_count == r0, "R4 all four resident", rd_count - r0, 0);
    rd(la_of(5, 5), "R3 fifth line", lat);
    check(rd_count - r0 == 1, "R5 fifth line fetched", rd_count - r0, 1);
    r0 = rd_count;
    rd(la_of(2, 5), "R3 B after evict", lat);
    check(rd_count == r0, "R5 B kept (A was pLRU victim)", rd_count - r0, 0);
    rd(la_of(1, 5), "R3 A after evict", lat);
    check(rd_count - r0 == 1, "R5 A evicted", rd_count - r0, 1);

    // R9 / R10 / R13 on set 9
    wr(la_of(1, 9), 32'hDEAD_0001);
    for (int t = 2; t <= 4; t++) rd(la_of(t, 9), "R3 set9 fill", lat);
    w0 = wr_count; r0 = rd_count;
    wr_extra = 12;
    rd(la_of(5, 9), "R3 E read", lat);
    rdc = rd_data_cyc;
    check(rd_count - r0 == 1, "R9 refill issued", rd_count - r0, 1);
    rd(la_of(1, 9), "R10 read of buffered line", lat);
    check(wr_count - w0 == 1, "R9 one write-back", wr_count - w0, 1);
    check(last_wr_addr == la_of(1, 9), "R9 write-back address", last_wr_addr, la_of(1, 9));
    check(last_wr_line[31:0] == 32'hDEAD_0001, "R9 write-back word0", last_wr_line[31:0], 32'hDEAD_0001);
    check(wr_seen_cyc > rdc, "R9 drain after refill", wr_seen_cyc, rdc);
    check(rd_hs_cyc > wr_hs_cyc, "R10 read after drain", rd_hs_cyc, wr_hs_cyc);
    wr_extra = 0;
    repeat (20) @(negedge clk);
    check(wr_count - w0 == 1, "R13 clean victim dropped", wr_count - w0, 1);

    // random normal-mode traffic
    for (int i = 0; i < 600; i++) begin
      a = (32'($urandom_range(0, 7)) << 11) | (32'($urandom_range(0, 3)) << 4) |
          (32'($urandom_range(0, 3)) << 2);
      if ($urandom_range(0, 2) == 0) wr(a, $urandom);
      else rd(a, "R3 random read", lat);
    end

    // R11 invalidate-all drops a dirty line
    wr(la_of(1, 12), 32'hBADD_0C0C);
    repeat (40) @(negedge clk);
    w0 = wr_count;
    pulse_inv();
    r0 = rd_count;
    rd(la_of(1, 12), "R11 stale memory value after invalidate", lat);
    check(rd_count - r0 == 1, "R11 miss after invalidate", rd_count - r0, 1);
    check(wr_count == w0, "R11 no write-back on invalidate", wr_count - w0, 0);

    // RAM mode
    ram_mode = 1'b1;
    @(negedge clk);
    req_waddr = 30'h1FCF_0004;
    @(negedge clk);
    check(bypass === 1'b1, "R8 bypass in window", bypass, 1);
    req_waddr = 30'h1F80_0004;
    @(negedge clk);
    check(bypass === 1'b0, "R8 no bypass outside window", bypass, 0);

    r0 = rd_count; w0 = wr_count;
    wr(32'h7F00_0010, 32'h1111_0000);
    wr(32'h7F00_0810, 32'h2222_0000);
    rd(32'h7F00_0010, "R6 RAM way2 read", lat);
    check(lat == 2, "R2 RAM latency", lat, 2);
    rd(32'h7F5A_3810, "R7 alias reaches way3 word", lat);
    rd(32'h7FFF_F010, "R7 top alias reaches way2 word", lat);
    check(rd_count == r0 && wr_count == w0, "R6 no external traffic",
          {rd_count - r0, wr_count - w0}, 0);

    // R5 RAM mode: two ways, exact LRU
    r0 = rd_count;
    rd(la_of(1, 5), "R3 ram-mode A", lat);
    rd(la_of(2, 5), "R3 ram-mode B", lat);
    rd(la_of(1, 5), "R3 ram-mode A again", lat);
    rd(la_of(2, 5), "R3 ram-mode B again", lat);
    check(rd_count - r0 == 2, "R5 two ways hold A and B", rd_count - r0, 2);
    rd(la_of(3, 5), "R3 ram-mode C", lat);
    r0 = rd_count;
    rd(la_of(2, 5), "R3 ram-mode B kept", lat);
    check(rd_count == r0, "R5 MRU way kept", rd_count - r0, 0);
    rd(la_of(1, 5), "R3 ram-mode A refetch", lat);
    check(rd_count - r0 == 1, "R5 LRU way evicted", rd_count - r0, 1);
    rd(32'h7F00_0010, "R6 RAM untouched by cache fills", lat);

    // random RAM-mode traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 0)
        a = 32'h7F00_0000 | (32'($urandom_range(0, 4095)) << 12) | (32'($urandom_range(0, 1023)) << 2);
      else
        a = (32'($urandom_range(0, 7)) << 11) | (32'($urandom_range(0, 3)) << 4) |
            (32'($urandom_range(0, 3)) << 2);
      if ($urandom_range(0, 2) == 0) wr(a, $urandom);
      else rd(a, "R6 random ram-mode read", lat);
    end

    repeat (20) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule